// File: doc/BRIEF.md
# Half-Duplex Line Driver Direction Controller

This block sits beside a UART transmit path and steers the direction-enable pin of a half-duplex differential line driver without software help. It watches the transmit FIFO write strobe, the FIFO empty flag and the busy flag of the transmit shifter. A queued byte switches the pin to its transmit level. The pin holds that level while characters are serialized. It returns to the receive level a full bit period after the stop bit of the final character. The bit period is measured with 16 sub-ticks of a 16x oversampled baud clock.

The block also shapes the transmit-empty interrupt. With the automatic function off, the interrupt follows the FIFO empty flag alone. With it on, the interrupt waits until the shifter is idle too. A polarity input selects which pin level means transmit. The serializer and the FIFO storage live outside this block.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset with `dir_inv_i`=0 and `auto_en_i`=1, `dir_o` is 1, which is the receive level, and the hold timer is cleared.
- R2: While `auto_en_i`=0, `tx_irq_o` equals `fifo_empty_i` whatever the value of `shift_busy_i`.
- R3: While `auto_en_i`=1, `tx_irq_o` is 1 only when `fifo_empty_i`=1 and `shift_busy_i`=0.
- R4: With `auto_en_i`=1, a cycle with `fifo_wr_i`=1 puts `dir_o` at the transmit level (0 when `dir_inv_i`=0) from the next clock edge.
- R5: In the transmit state, `dir_o` stays at the transmit level while the FIFO is non-empty or the shifter is busy.
- R6: The last character ends when the transmit state sees `fifo_empty_i`=1, `shift_busy_i`=0 and no write. From that edge, `dir_o` holds the transmit level through 15 cycles with `baud_tick_i`=1. It switches to the receive level on the edge that samples the 16th such tick.
- R7: A write during the hold window cancels it. `dir_o` stays at the transmit level, and a later release again needs a full 16 ticks.
- R8: `dir_inv_i`=1 inverts the pin: receive is 0 and transmit is 1.
- R9: A cycle with `auto_en_i`=0 returns the controller to the receive state at the next edge and cancels any pending hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | Enables automatic direction control and the delayed interrupt |
| dir_inv_i | input | 1 | Inverts the direction pin polarity |
| fifo_wr_i | input | 1 | Transmit FIFO write strobe |
| fifo_empty_i | input | 1 | Transmit FIFO is empty |
| shift_busy_i | input | 1 | Transmit shifter is sending a character |
| baud_tick_i | input | 1 | 16x oversampled baud sub-tick |
| dir_o | output | 1 | Line driver direction enable |
| tx_irq_o | output | 1 | Transmit-empty interrupt |

## Verification
Two functions can fall in the same cycle: the final baud tick of the hold window, and a new FIFO write that should cancel the release. The random stimulus drives writes and ticks independently, so this collision comes up many times. A directed case also lands a write partway through the hold window. The result is judged against a bench-side model of the requirements. It must keep the transmit level, and it must need a full fresh count of 16 ticks before the next release.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    ST_RX   = 2'd0,
    ST_TX   = 2'd1,
    ST_HOLD = 2'd2
  } dir_st_e;
endpackage

// File: rtl/rs485_hold_timer.sv
module rs485_hold_timer #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !tick_i) |=> $stable(cnt_q));
  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_clr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    wr_i,
  input  logic    empty_i,
  input  logic    busy_i,
  input  logic    done_i,
  output dir_st_e state_o,
  output logic    run_o,
  output logic    clear_o
);
  dir_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = ST_RX;
    end else begin
      unique case (st_q)
        ST_RX:   if (wr_i) st_d = ST_TX;
        ST_TX:   if (!wr_i && empty_i && !busy_i) st_d = ST_HOLD;
        ST_HOLD: begin
          if (wr_i)        st_d = ST_TX;
          else if (done_i) st_d = ST_RX;
        end
        default: st_d = ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RX;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign run_o   = (st_q == ST_HOLD);
  assign clear_o = (st_q != ST_HOLD);

  p_wr_to_tx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i) |=> (st_q == ST_TX));
  p_keep_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_TX && (!empty_i || busy_i)) |=> (st_q == ST_TX));
  p_off_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == ST_RX));
  p_no_skip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX) |=> (st_q != ST_RX) || !$past(en_i));
endmodule

// File: rtl/rs485_irq_gate.sv
module rs485_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic empty_i,
  input  logic busy_i,
  output logic irq_o
);
  always_comb begin
    irq_o = empty_i;
    if (en_i && busy_i) irq_o = 1'b0;
  end

  p_irq_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && busy_i) |-> !irq_o);
  p_irq_early_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && empty_i && busy_i) |-> irq_o);
  p_irq_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_i |-> !irq_o);
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int unsigned BIT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic dir_inv_i,
  input  logic fifo_wr_i,
  input  logic fifo_empty_i,
  input  logic shift_busy_i,
  input  logic baud_tick_i,
  output logic dir_o,
  output logic tx_irq_o
);
  dir_st_e st;
  logic    run, clear, done;

  rs485_dir_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (auto_en_i),
    .wr_i    (fifo_wr_i),
    .empty_i (fifo_empty_i),
    .busy_i  (shift_busy_i),
    .done_i  (done),
    .state_o (st),
    .run_o   (run),
    .clear_o (clear)
  );

  rs485_hold_timer #(.TICKS(BIT_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .run_i   (run),
    .tick_i  (baud_tick_i),
    .done_o  (done)
  );

  rs485_irq_gate u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (auto_en_i),
    .empty_i (fifo_empty_i),
    .busy_i  (shift_busy_i),
    .irq_o   (tx_irq_o)
  );

  // receive level is high unless inverted
  assign dir_o = (st == ST_RX) ^ dir_inv_i;

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !fifo_wr_i && done) |=> (dir_o == !dir_inv_i));
  p_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && fifo_wr_i && run) |=> (dir_o == dir_inv_i));
  p_done_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (baud_tick_i && st == ST_HOLD));
endmodule

// File: tb/rs485_dir_ctrl_tb.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b1, dir_inv = 1'b0, fifo_wr = 1'b0;
  logic fifo_empty = 1'b1, shift_busy = 1'b0, baud_tick = 1'b0;
  logic dir, tx_irq;

  int errors = 0, checks = 0;
  int fcnt = 0, sh = 0;
  int m_st = 0;   // 0 rx, 1 tx, 2 hold
  int m_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rs485_dir_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .auto_en_i(auto_en), .dir_inv_i(dir_inv),
    .fifo_wr_i(fifo_wr), .fifo_empty_i(fifo_empty), .shift_busy_i(shift_busy),
    .baud_tick_i(baud_tick), .dir_o(dir), .tx_irq_o(tx_irq)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_dir();
    return logic'(m_st == 0) ^ dir_inv;
  endfunction

  function automatic logic exp_irq();
    return auto_en ? (fifo_empty && !shift_busy) : fifo_empty;
  endfunction

  function automatic string dir_tag();
    if (!auto_en) return "R9";
    if (dir_inv)  return "R8";
    if (m_st == 1) return "R5";
    if (m_st == 2) return "R6";
    return "R4";
  endfunction

  task automatic model_adv();
    if (!auto_en) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (fifo_wr) m_st = 1;
        1: if (!fifo_wr && fifo_empty && !shift_busy) begin m_st = 2; m_cnt = 0; end
        default: begin
          if (fifo_wr) m_st = 1;
          else if (baud_tick) begin
            if (m_cnt == 15) m_st = 0;
            else m_cnt++;
          end
        end
      endcase
    end
  endtask

  task automatic env_adv(input bit wr);
    if (wr) fcnt++;
    if (sh == 0 && fcnt > 0) begin
      fcnt--;
      sh = 8 + int'($urandom_range(0, 16));
    end else if (sh > 0) sh--;
    fifo_empty = (fcnt == 0);
    shift_busy = (sh != 0);
  endtask

  // called just after a falling edge
  task automatic step(input bit wr, input bit tick);
    fifo_wr = wr; baud_tick = tick;
    #1;
    chk(tx_irq, exp_irq(), auto_en ? "R3" : "R2");
    model_adv();
    @(posedge clk); @(negedge clk);
    env_adv(wr);
    fifo_wr = 1'b0; baud_tick = 1'b0;
    #0.5;
    chk(dir, exp_dir(), dir_tag());
  endtask

  task automatic run_to_hold();
    for (int i = 0; i < 200 && m_st != 2; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5117));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(dir, 1'b1, "R1");
    chk(tx_irq, 1'b1, "R1");

    // R4/R5/R3: single byte
    step(1'b1, 1'b0);
    chk(dir, 1'b0, "R4");
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1);
      chk(dir, 1'b0, "R5");
    end
    run_to_hold();
    // R6: exact 16-tick release
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1);
    chk(dir, 1'b0, "R6");
    step(1'b0, 1'b0);
    chk(dir, 1'b0, "R6");
    step(1'b0, 1'b1);
    chk(dir, 1'b1, "R6");

    // R7: write in the hold window restarts count
    step(1'b1, 1'b0);
    run_to_hold();
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk(dir, 1'b0, "R7");
    run_to_hold();
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1);
    chk(dir, 1'b0, "R7");
    step(1'b0, 1'b1);
    chk(dir, 1'b1, "R7");

    // R2: disabled, irq ignores busy
    auto_en = 1'b0;
    step(1'b1, 1'b0);
    chk(dir, 1'b1, "R9");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    checks++;
    if (!(fifo_empty && shift_busy)) begin
      errors++;
      $display("FAIL R2: actual=empty%0b busy%0b expected=empty1 busy1", fifo_empty, shift_busy);
    end
    #1 chk(tx_irq, 1'b1, "R2");
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);

    // R9: disabling mid-transmit returns to receive
    auto_en = 1'b1;
    step(1'b1, 1'b0);
    chk(dir, 1'b0, "R9");
    auto_en = 1'b0;
    step(1'b0, 1'b0);
    chk(dir, 1'b1, "R9");
    auto_en = 1'b1;
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);

    // R8: inverted polarity
    dir_inv = 1'b1;
    #0.5 chk(dir, 1'b0, "R8");
    step(1'b1, 1'b0);
    chk(dir, 1'b1, "R8");
    run_to_hold();
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1);
    chk(dir, 1'b0, "R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) auto_en = ~auto_en;
      if ($urandom_range(0, 399) == 0) dir_inv = ~dir_inv;
      step(($urandom_range(0, 29) == 0), ($urandom_range(0, 2) == 0));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule